// File: doc/BRIEF.md
# Three-Wire Configuration Word Loader

This block takes configuration words for a dual-channel frequency synthesizer from a three-wire serial port made up of a serial clock, a serial data line and a load strobe. All three lines are asynchronous to the system clock. The block synchronizes them and detects their edges. On each rising edge of the serial clock it shifts one data bit into a 22-bit word register. The word arrives most significant bit first.

When the load strobe rises, the two lowest word bits act as a destination code. They select one of four holding registers: the reference setting of channel 1 or channel 2, or the feedback-divider setting of channel 1 or channel 2. Only the selected register takes its fields from the word. The reference registers hold:

- a 15-bit reference ratio,
- phase-polarity, pump-boost and pump-tristate flags,
- two monitor-select bits.

The divider registers hold:

- a 7-bit swallow count,
- an 11-bit main count,
- a prescaler-mode bit,
- a power-save bit.

A small state machine sequences the transfer. Its states are:

- `ST_SHIFT`: accepts serial clock edges.
- `ST_LOAD`: a single cycle in which the selected register is written.
- `ST_HOLD`: the strobe is still high, and serial clock edges are ignored.

Its transitions are:

- `ST_SHIFT` to `ST_LOAD` when the strobe rises.
- `ST_LOAD` to `ST_HOLD`, always.
- `ST_HOLD` to `ST_SHIFT` when the strobe falls.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, both reference registers hold ratio 3 with all flags 0. Both divider registers hold swallow count 0, main count 3, prescaler-mode 0 and power-save 1.
- R2: Each rising edge of the serial clock shifts in one bit while the loader is idle. Word bit k (k = 1 is the LSB) is the (23 - k)-th bit sent, so the MSB goes first.
- R3: A rising edge of the load strobe writes exactly one holding register, once. The other three registers keep their values.
- R4: The destination code is formed from bit 1 (c1) and bit 2 (c2). {c1,c2} = 00 selects the channel 2 reference, 01 the channel 1 reference, 10 the channel 2 divider and 11 the channel 1 divider.
- R5: Reference word layout: ratio in bits 3..17 with bit 3 as its LSB, then phase polarity in bit 18, pump boost in 19, pump tristate in 20, monitor select low in 21 and monitor select high in 22.
- R6: Divider word layout: swallow count in bits 3..9 with bit 3 as its LSB, main count in bits 10..20 with bit 10 as its LSB, prescaler mode in bit 21 and power save in bit 22.
- R7: A reference word whose ratio is below 3 is discarded and the target register keeps its old value. Ratios from 3 to 32767 are accepted.
- R8: Serial clock edges that arrive while the strobe is high neither shift nor change any register. Shifting resumes after the strobe falls.
- R9: A channel whose power-save bit is 1 still accepts both reference and divider words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_le | input | 1 | Load strobe (asynchronous) |
| ch1_ref_ratio | output | 15 | Channel 1 reference ratio |
| ch1_pd_pol | output | 1 | Channel 1 phase polarity |
| ch1_cp_boost | output | 1 | Channel 1 pump boost |
| ch1_cp_tri | output | 1 | Channel 1 pump tristate |
| ch1_mon_lo | output | 1 | Channel 1 monitor select low |
| ch1_mon_hi | output | 1 | Channel 1 monitor select high |
| ch1_swallow | output | 7 | Channel 1 swallow count |
| ch1_main_cnt | output | 11 | Channel 1 main count |
| ch1_pre_mode | output | 1 | Channel 1 prescaler mode |
| ch1_pwr_save | output | 1 | Channel 1 power save |
| ch2_ref_ratio | output | 15 | Channel 2 reference ratio |
| ch2_pd_pol | output | 1 | Channel 2 phase polarity |
| ch2_cp_boost | output | 1 | Channel 2 pump boost |
| ch2_cp_tri | output | 1 | Channel 2 pump tristate |
| ch2_mon_lo | output | 1 | Channel 2 monitor select low |
| ch2_mon_hi | output | 1 | Channel 2 monitor select high |
| ch2_swallow | output | 7 | Channel 2 swallow count |
| ch2_main_cnt | output | 11 | Channel 2 main count |
| ch2_pre_mode | output | 1 | Channel 2 prescaler mode |
| ch2_pwr_save | output | 1 | Channel 2 power save |

## Verification
The bench builds the loader with its default two-stage synchronizers and fixed 22-bit word. At that size the full swallow range 0..127 can be swept across both divider registers. Each swallow value is paired with an arithmetically derived main count and mode bits. The same build makes it cheap to step through ratios 0..7 around the rejection floor and a scattered set up to 32767, with every flag pattern, on both reference registers. After each load, all four registers are compared with a model built from the bit layout. A misrouted destination or a shifted field therefore appears as a mismatch somewhere.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int WORD_W   = 22;
    localparam int CTRL_W   = 2;
    localparam int R_W      = 15;
    localparam int A_W      = 7;
    localparam int N_W      = 11;
    localparam int R_MIN    = 3;
    localparam int N_RST    = 3;
    localparam int R_LSB    = CTRL_W;
    localparam int FLAG_LSB = R_LSB + R_W;
    localparam int A_LSB    = CTRL_W;
    localparam int N_LSB    = A_LSB + A_W;
    localparam int SW_POS   = N_LSB + N_W;
    localparam int PS_POS   = SW_POS + 1;

    localparam logic [1:0] DEST_REF2 = 2'b00;
    localparam logic [1:0] DEST_REF1 = 2'b01;
    localparam logic [1:0] DEST_DIV2 = 2'b10;
    localparam logic [1:0] DEST_DIV1 = 2'b11;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic           fc;
        logic           cmc;
        logic           zc;
        logic           mlo;
        logic           mhi;
    } ref_cfg_t;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [N_W-1:0] n;
        logic           sw;
        logic           ps;
    } div_cfg_t;

    function automatic logic [1:0] dest_of(input logic [WORD_W-1:0] w);
        return {w[0], w[1]};
    endfunction

    function automatic ref_cfg_t decode_ref(input logic [WORD_W-1:0] w);
        ref_cfg_t f;
        f.r   = w[R_LSB +: R_W];
        f.fc  = w[FLAG_LSB];
        f.cmc = w[FLAG_LSB+1];
        f.zc  = w[FLAG_LSB+2];
        f.mlo = w[FLAG_LSB+3];
        f.mhi = w[FLAG_LSB+4];
        return f;
    endfunction

    function automatic div_cfg_t decode_div(input logic [WORD_W-1:0] w);
        div_cfg_t f;
        f.a  = w[A_LSB +: A_W];
        f.n  = w[N_LSB +: N_W];
        f.sw = w[SW_POS];
        f.ps = w[PS_POS];
        return f;
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d_async;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shift_fsm.sv
module cfg_shift_fsm
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              le_s,
    output logic              load_stb,
    output logic [WORD_W-1:0] word
);
    typedef enum logic [1:0] {ST_SHIFT, ST_LOAD, ST_HOLD} st_e;

    st_e               state_q, state_d;
    logic              sclk_d, le_d;
    logic              sclk_rise, le_rise, le_fall;
    logic [WORD_W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            le_d   <= le_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign le_rise   = le_s & ~le_d;
    assign le_fall   = ~le_s & le_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT: if (le_rise) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_HOLD;
            ST_HOLD:  if (le_fall || !le_s) state_d = ST_SHIFT;
            default:  state_d = ST_SHIFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHIFT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (state_q == ST_SHIFT && sclk_rise && !le_rise) begin
            shreg_q <= {shreg_q[WORD_W-2:0], sdat_s};
        end
    end

    assign load_stb = (state_q == ST_LOAD);
    assign word     = shreg_q;

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD |=> state_q == ST_HOLD); // R3
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HOLD |=> $stable(shreg_q)); // R8
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sclk_rise && !le_rise)
        |=> shreg_q == {$past(shreg_q[WORD_W-2:0]), $past(sdat_s)}); // R2
endmodule

// File: rtl/cfg_chan_latch.sv
module cfg_chan_latch
    import cfg_pkg::*;
#(
    parameter logic [1:0] REF_CODE = DEST_REF1,
    parameter logic [1:0] DIV_CODE = DEST_DIV1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [WORD_W-1:0] word,
    output ref_cfg_t          ref_q,
    output div_cfg_t          div_q
);
    ref_cfg_t ref_next;
    div_cfg_t div_next;
    logic     hit_ref, hit_div, ratio_ok;

    assign ref_next = decode_ref(word);
    assign div_next = decode_div(word);
    assign hit_ref  = load_stb && (dest_of(word) == REF_CODE);
    assign hit_div  = load_stb && (dest_of(word) == DIV_CODE);
    assign ratio_ok = (ref_next.r >= R_W'(R_MIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '{r: R_W'(R_MIN), fc: 1'b0, cmc: 1'b0, zc: 1'b0, mlo: 1'b0, mhi: 1'b0};
        end else if (hit_ref && ratio_ok) begin
            ref_q <= ref_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '{a: '0, n: N_W'(N_RST), sw: 1'b0, ps: 1'b1};
        end else if (hit_div) begin
            div_q <= div_next;
        end
    end

    AST_REF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ref_q.r >= R_W'(R_MIN)); // R7
    AST_REF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && dest_of(word) == REF_CODE && decode_ref(word).r < R_W'(R_MIN))
        |=> $stable(ref_q)); // R7
    AST_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_stb && dest_of(word) == REF_CODE) |=> $stable(ref_q)); // R3
    AST_DIV_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && dest_of(word) == DIV_CODE) |=> div_q == $past(decode_div(word))); // R6
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_le,
    output logic [14:0]    ch1_ref_ratio,
    output logic           ch1_pd_pol,
    output logic           ch1_cp_boost,
    output logic           ch1_cp_tri,
    output logic           ch1_mon_lo,
    output logic           ch1_mon_hi,
    output logic [6:0]     ch1_swallow,
    output logic [10:0]    ch1_main_cnt,
    output logic           ch1_pre_mode,
    output logic           ch1_pwr_save,
    output logic [14:0]    ch2_ref_ratio,
    output logic           ch2_pd_pol,
    output logic           ch2_cp_boost,
    output logic           ch2_cp_tri,
    output logic           ch2_mon_lo,
    output logic           ch2_mon_hi,
    output logic [6:0]     ch2_swallow,
    output logic [10:0]    ch2_main_cnt,
    output logic           ch2_pre_mode,
    output logic           ch2_pwr_save
);
    localparam int NCH = 2;

    logic [2:0]        pins_s;
    logic              load_stb;
    logic [WORD_W-1:0] word;
    ref_cfg_t          ref_q [NCH];
    div_cfg_t          div_q [NCH];

    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_le, ser_dat, ser_clk}),
        .d_sync  (pins_s)
    );

    cfg_shift_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[0]),
        .sdat_s   (pins_s[1]),
        .le_s     (pins_s[2]),
        .load_stb (load_stb),
        .word     (word)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            cfg_chan_latch #(
                .REF_CODE((c == 0) ? DEST_REF1 : DEST_REF2),
                .DIV_CODE((c == 0) ? DEST_DIV1 : DEST_DIV2)
            ) u_latch (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_stb (load_stb),
                .word     (word),
                .ref_q    (ref_q[c]),
                .div_q    (div_q[c])
            );
        end
    endgenerate

    assign {ch1_ref_ratio, ch1_pd_pol, ch1_cp_boost, ch1_cp_tri, ch1_mon_lo, ch1_mon_hi} = ref_q[0];
    assign {ch2_ref_ratio, ch2_pd_pol, ch2_cp_boost, ch2_cp_tri, ch2_mon_lo, ch2_mon_hi} = ref_q[1];
    assign {ch1_swallow, ch1_main_cnt, ch1_pre_mode, ch1_pwr_save} = div_q[0];
    assign {ch2_swallow, ch2_main_cnt, ch2_pre_mode, ch2_pwr_save} = div_q[1];

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({$changed(ref_q[0]), $changed(ref_q[1]),
                    $changed(div_q[0]), $changed(div_q[1])}) <= 1); // R3
endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;

    logic [14:0] r1, r2;
    logic        fc1, cm1, zc1, ml1, mh1, fc2, cm2, zc2, ml2, mh2;
    logic [6:0]  a1, a2;
    logic [10:0] n1, n2;
    logic        sw1, ps1, sw2, ps2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [19:0] m_ref [2];
    logic [19:0] m_div [2];

    always #10 clk = ~clk;

    serial_cfg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ch1_ref_ratio(r1), .ch1_pd_pol(fc1), .ch1_cp_boost(cm1), .ch1_cp_tri(zc1),
        .ch1_mon_lo(ml1), .ch1_mon_hi(mh1), .ch1_swallow(a1), .ch1_main_cnt(n1),
        .ch1_pre_mode(sw1), .ch1_pwr_save(ps1),
        .ch2_ref_ratio(r2), .ch2_pd_pol(fc2), .ch2_cp_boost(cm2), .ch2_cp_tri(zc2),
        .ch2_mon_lo(ml2), .ch2_mon_hi(mh2), .ch2_swallow(a2), .ch2_main_cnt(n2),
        .ch2_pre_mode(sw2), .ch2_pwr_save(ps2)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk(input logic d);
        ser_dat = d;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(input logic [21:0] w);
        for (int i = 21; i >= 0; i--) pulse_sclk(w[i]);
        wait_clk(2);
        ser_le = 1'b1;
        wait_clk(10);
        ser_le = 1'b0;
        wait_clk(10);
    endtask

    // model: bit1 = c1, bit2 = c2; c1=0 -> reference, c2=1 -> channel 1
    function automatic void apply_model(input logic [21:0] w);
        int ch;
        ch = w[1] ? 0 : 1;
        if (!w[0]) begin
            if (w[16:2] >= 15'd3)
                m_ref[ch] = {w[16:2], w[17], w[18], w[19], w[20], w[21]};
        end else begin
            m_div[ch] = {w[8:2], w[19:9], w[20], w[21]};
        end
    endfunction

    function automatic logic [21:0] ref_word(input int ch, input logic [14:0] r, input logic [4:0] fl);
        return {fl[4], fl[3], fl[2], fl[1], fl[0], r, (ch == 0) ? 1'b1 : 1'b0, 1'b0};
    endfunction

    function automatic logic [21:0] div_word(input int ch, input logic [6:0] a, input logic [10:0] n,
                                             input logic sw, input logic ps);
        return {ps, sw, n, a, (ch == 0) ? 1'b1 : 1'b0, 1'b1};
    endfunction

    task automatic cmp(input string tag, input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp({tag, " ch1 ref"}, {r1, fc1, cm1, zc1, ml1, mh1}, m_ref[0]);
        cmp({tag, " ch2 ref"}, {r2, fc2, cm2, zc2, ml2, mh2}, m_ref[1]);
        cmp({tag, " ch1 div"}, {a1, n1, sw1, ps1}, m_div[0]);
        cmp({tag, " ch2 div"}, {a2, n2, sw2, ps2}, m_div[1]);
    endtask

    task automatic load_and_check(input logic [21:0] w, input string tag);
        send_word(w);
        apply_model(w);
        check_all(tag);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_ref[c] = {15'd3, 5'b0};
            m_div[c] = {7'd0, 11'd3, 1'b0, 1'b1};
        end
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R1 reset");

        // R9: channel 1 still in power save from reset, loads must land
        load_and_check(ref_word(0, 15'd100, 5'b10101), "R9 ref under power save");
        load_and_check(div_word(0, 7'd9, 11'd77, 1'b1, 1'b1), "R9 div with ps=1");
        load_and_check(ref_word(0, 15'd321, 5'b01010), "R9 ref after ps=1 div");

        // R5 R7 R4 R2: reference ratio sweep, flags from index
        for (int i = 0; i < 40; i++) begin
            logic [14:0] r;
            if (i < 8)       r = 15'(i);
            else if (i == 39) r = 15'd32767;
            else             r = 15'((i * 823) % 32768);
            load_and_check(ref_word(i % 2, r, 5'(i)), "R2/R3/R4/R5/R7 ref sweep");
        end

        // R6 R4 R3: full swallow sweep on both divider registers
        for (int a = 0; a < 128; a++) begin
            logic [10:0] n;
            n = 11'(3 + (a * 37) % 2045);
            load_and_check(div_word((a >> 2) % 2, 7'(a), n, a[0], a[1]), "R3/R4/R6 div sweep");
        end

        // R8: serial clocks during strobe-high are ignored
        send_word(ref_word(0, 15'd4660, 5'b00110));
        apply_model(ref_word(0, 15'd4660, 5'b00110));
        ser_le = 1'b1;
        wait_clk(10);
        for (int k = 0; k < 5; k++) pulse_sclk(1'b1);
        wait_clk(6);
        check_all("R8 clocks while strobe high");
        ser_le = 1'b0;
        wait_clk(10);
        ser_le = 1'b1;
        wait_clk(10);
        ser_le = 1'b0;
        wait_clk(10);
        check_all("R8 reload after ignored clocks");
        // shifting resumes after strobe falls
        load_and_check(div_word(1, 7'd5, 11'd2000, 1'b1, 1'b0), "R8 shift resumes");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule